// File: doc/BRIEF.md
# Parallel Bus Initiator Phase Sequencer

This block is the initiator side of a simplified parallel peripheral bus. The host asks for one command transaction to a chosen target ID. The block waits for the bus to go free and then competes for it against the other devices. After winning, it selects the target and steps through the transfer phases in a fixed order: command bytes, data bytes, one status byte and then a message byte. Every byte in these four phases is moved with a four-phase request/acknowledge strobe pair.

Arbitration is decided inside the block. The competing device IDs arrive as one request bit per ID on an ID bus of 8 or 16 lines. The initiator adds its own bit, and the highest ID that is set wins. The target can interrupt the data phase with a message. A disconnect message frees the bus. The transaction then waits for the same target to reselect the initiator and carries on with the data bytes still owed. Save-pointer and restore-pointer messages let the target rewind the data count to a saved point.

The current phase is shown on a 3-bit code. The command byte index and the count of data bytes still owed are also brought out, so the host side can supply or accept the right byte.

Top module: `bus_phase_seq`

## Requirements
- R1: After reset, `phase_o` is bus free, and `sel_o`, `byte_req_o` and `done_o` are all low. The phase codes are: 0 bus free, 1 arbitration, 2 selection, 3 reselection, 4 command, 5 data, 6 message, 7 status.
- R2: A `start_i` pulse is accepted only in bus free, and only when no transaction is pending. Arbitration is entered on the clock edge after a bus-free cycle with a pending (or just accepted) request and `bus_busy_i` low. It is never entered while `bus_busy_i` is high.
- R3: Arbitration lasts one cycle and uses fixed priority. Among the set bits of `arb_req_i` plus bit `OWN_ID`, the highest index wins. On a win the next phase is selection. On a loss the next phase is bus free, the request stays pending, and arbitration is retried.
- R4: In selection, `sel_o` is high and `sel_id_o` carries the requested target ID. The phase moves to command on the edge where `sel_ack_i` is high.
- R5: In the command, data, status and message phases, `byte_req_o` stays high until `byte_ack_i` is seen. It is low in the cycle after the acknowledge. It is not raised again until `byte_ack_i` has returned low.
- R6: The command phase moves exactly `CMD_LEN` bytes, with `cmd_idx_o` counting 0, 1, and so on. It then moves to data, or straight to status when the requested data length is zero.
- R7: In the data phase, `data_left_o` shows the bytes still owed and drops by one per acknowledged byte. When the last byte is acknowledged the phase moves to status.
- R8: The status byte is taken from `in_byte_i` at its acknowledge and held on `status_o`. The next phase is message.
- R9: Message byte 0x00 (command complete) returns the bus to free and clears the transaction. It also pulses `done_o` high for exactly one cycle, in the first bus-free cycle.
- R10: Message byte 0x04 (disconnect) returns the bus to free. While disconnected, `start_i` is ignored and no arbitration happens. Reselection is entered only when `resel_i` is high, `resel_id_i` equals the target ID and the bus is free. Reselection lasts one cycle and then goes to data with the owed count kept, or to status when nothing is owed.
- R11: Message byte 0x02 saves the owed count. Message byte 0x03 restores the owed count to the saved value, which is the full length at start. Any other message byte leaves the count alone. In all three cases the phase resumes to data, or to status if nothing is owed.
- R12: When `msg_req_i` is high at a data byte acknowledge, that byte is still counted and the next phase is message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Host request for a new transaction |
| tgt_id_i | input | IDX_W | Target ID for the new transaction |
| data_len_i | input | LEN_W | Number of data bytes for the new transaction |
| bus_busy_i | input | 1 | Another device currently holds the bus |
| arb_req_i | input | ID_W | Competing arbitration requests, one bit per device ID |
| sel_ack_i | input | 1 | Target has answered the selection |
| resel_i | input | 1 | A target is reselecting this initiator |
| resel_id_i | input | IDX_W | ID of the reselecting target |
| byte_ack_i | input | 1 | Byte acknowledge strobe |
| msg_req_i | input | 1 | Target asks for a message phase after the current data byte |
| in_byte_i | input | 8 | Status or message byte from the target |
| phase_o | output | 3 | Current bus phase code |
| sel_o | output | 1 | Selection asserted |
| sel_id_o | output | IDX_W | Target ID being selected |
| byte_req_o | output | 1 | Byte request strobe |
| cmd_idx_o | output | CW | Index of the current command byte |
| data_left_o | output | LEN_W | Data bytes still owed |
| status_o | output | 8 | Last captured status byte |
| done_o | output | 1 | One-cycle transaction-complete pulse |

## Verification
Each phase change is registered, so it appears one cycle after the input that causes it. Start moves bus free to arbitration one cycle later, and arbitration resolves to selection or bus free one cycle after that. An acknowledge drops `byte_req_o` and moves the phase, count or status in the next cycle. A released acknowledge brings the request back one cycle after that, so each byte takes two cycles. `done_o` is valid in the single cycle after the command-complete acknowledge. The bench drives inputs on the falling edge and samples every output on the following falling edge, half a period after the rising edge that updates it. Its expected values come from bench functions for the arbitration winner and from the counts of bytes it has itself moved.

// File: rtl/bus_phase_pkg.sv
package bus_phase_pkg;

   typedef enum logic [2:0] {
      PH_FREE   = 3'd0,
      PH_ARB    = 3'd1,
      PH_SEL    = 3'd2,
      PH_RESEL  = 3'd3,
      PH_CMD    = 3'd4,
      PH_DATA   = 3'd5,
      PH_MSG    = 3'd6,
      PH_STATUS = 3'd7
   } phase_e;

   localparam logic [7:0] MSG_COMPLETE = 8'h00;
   localparam logic [7:0] MSG_SAVE_PTR = 8'h02;
   localparam logic [7:0] MSG_REST_PTR = 8'h03;
   localparam logic [7:0] MSG_DISCONN  = 8'h04;

   function automatic phase_e resume_phase(input int unsigned owed);
      return (owed == 0) ? PH_STATUS : PH_DATA;
   endfunction

endpackage

// File: rtl/bps_arbiter.sv
module bps_arbiter #(
   parameter int ID_W = 8
) (
   input  logic [ID_W-1:0] req_i,
   output logic [ID_W-1:0] grant_o
);

   for (genvar i = 0; i < ID_W; i++) begin : g_slot
      if (i == ID_W - 1) begin : g_top
         assign grant_o[i] = req_i[i];
      end else begin : g_lower
         assign grant_o[i] = req_i[i] & ~(|req_i[ID_W-1:i+1]);
      end
   end

endmodule

// File: rtl/bps_handshake.sv
module bps_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic ack_i,
   output logic req_o,
   output logic done_o
);

   logic rel_q;

   assign req_o  = active_i & ~rel_q;
   assign done_o = req_o & ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q <= 1'b0;
      end else if (done_o) begin
         rel_q <= 1'b1;
      end else if (!ack_i) begin
         rel_q <= 1'b0;
      end
   end

endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
   import bus_phase_pkg::*;
#(
   parameter int ID_W    = 8,
   parameter int OWN_ID  = 3,
   parameter int CMD_LEN = 6,
   parameter int LEN_W   = 8,
   localparam int IDX_W  = $clog2(ID_W),
   localparam int CW     = (CMD_LEN > 1) ? $clog2(CMD_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] tgt_id_i,
   input  logic [LEN_W-1:0] data_len_i,
   input  logic             bus_busy_i,
   input  logic [ID_W-1:0]  arb_req_i,
   input  logic             sel_ack_i,
   input  logic             resel_i,
   input  logic [IDX_W-1:0] resel_id_i,
   input  logic             byte_ack_i,
   input  logic             msg_req_i,
   input  logic [7:0]       in_byte_i,
   output logic [2:0]       phase_o,
   output logic             sel_o,
   output logic [IDX_W-1:0] sel_id_o,
   output logic             byte_req_o,
   output logic [CW-1:0]    cmd_idx_o,
   output logic [LEN_W-1:0] data_left_o,
   output logic [7:0]       status_o,
   output logic             done_o
);

   localparam logic [CW-1:0]   CMD_LAST = CW'(CMD_LEN - 1);
   localparam logic [ID_W-1:0] OWN_BIT  = {{(ID_W-1){1'b0}}, 1'b1} << OWN_ID;

   if (!(ID_W == 8 || ID_W == 16)) begin : g_bad_width
      $error("ID bus width must be 8 or 16");
   end
   if (OWN_ID < 0 || OWN_ID >= ID_W) begin : g_bad_own
      $error("OWN_ID outside the ID bus");
   end
   if (CMD_LEN < 1) begin : g_bad_cmd
      $error("CMD_LEN must be at least one");
   end

   phase_e           state_q;
   logic             pend_q;
   logic             disc_q;
   logic [IDX_W-1:0] tgt_q;
   logic [LEN_W-1:0] owed_q;
   logic [LEN_W-1:0] saved_q;
   logic [CW-1:0]    cmd_cnt_q;
   logic [7:0]       status_q;
   logic             done_q;

   logic [ID_W-1:0]  grant;
   logic             own_win;
   logic             byte_phase;
   logic             byte_done;

   bps_arbiter #(.ID_W(ID_W)) u_arb (
      .req_i   (arb_req_i | OWN_BIT),
      .grant_o (grant)
   );
   assign own_win = grant[OWN_ID];

   assign byte_phase = (state_q == PH_CMD) || (state_q == PH_DATA) ||
                       (state_q == PH_STATUS) || (state_q == PH_MSG);

   bps_handshake u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (byte_phase),
      .ack_i    (byte_ack_i),
      .req_o    (byte_req_o),
      .done_o   (byte_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PH_FREE;
         pend_q    <= 1'b0;
         disc_q    <= 1'b0;
         tgt_q     <= '0;
         owed_q    <= '0;
         saved_q   <= '0;
         cmd_cnt_q <= '0;
         status_q  <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            PH_FREE: begin
               if (start_i && !pend_q && !disc_q) begin
                  pend_q  <= 1'b1;
                  tgt_q   <= tgt_id_i;
                  owed_q  <= data_len_i;
                  saved_q <= data_len_i;
               end
               if (disc_q) begin
                  if (resel_i && (resel_id_i == tgt_q) && !bus_busy_i) begin
                     state_q <= PH_RESEL;
                  end
               end else if ((pend_q || start_i) && !bus_busy_i) begin
                  state_q <= PH_ARB;
               end
            end
            PH_ARB: begin
               state_q <= own_win ? PH_SEL : PH_FREE;
            end
            PH_SEL: begin
               if (sel_ack_i) begin
                  state_q   <= PH_CMD;
                  cmd_cnt_q <= '0;
               end
            end
            PH_RESEL: begin
               disc_q  <= 1'b0;
               state_q <= resume_phase(int'(owed_q));
            end
            PH_CMD: begin
               if (byte_done) begin
                  if (cmd_cnt_q == CMD_LAST) begin
                     state_q <= resume_phase(int'(owed_q));
                  end else begin
                     cmd_cnt_q <= cmd_cnt_q + 1'b1;
                  end
               end
            end
            PH_DATA: begin
               if (byte_done) begin
                  owed_q <= owed_q - 1'b1;
                  if (msg_req_i) begin
                     state_q <= PH_MSG;
                  end else if (owed_q == LEN_W'(1)) begin
                     state_q <= PH_STATUS;
                  end
               end
            end
            PH_STATUS: begin
               if (byte_done) begin
                  status_q <= in_byte_i;
                  state_q  <= PH_MSG;
               end
            end
            PH_MSG: begin
               if (byte_done) begin
                  unique case (in_byte_i)
                     MSG_COMPLETE: begin
                        state_q <= PH_FREE;
                        pend_q  <= 1'b0;
                        done_q  <= 1'b1;
                     end
                     MSG_DISCONN: begin
                        state_q <= PH_FREE;
                        disc_q  <= 1'b1;
                     end
                     MSG_SAVE_PTR: begin
                        saved_q <= owed_q;
                        state_q <= resume_phase(int'(owed_q));
                     end
                     MSG_REST_PTR: begin
                        owed_q  <= saved_q;
                        state_q <= resume_phase(int'(saved_q));
                     end
                     default: begin
                        state_q <= resume_phase(int'(owed_q));
                     end
                  endcase
               end
            end
            default: state_q <= PH_FREE;
         endcase
      end
   end

   assign phase_o     = state_q;
   assign sel_o       = (state_q == PH_SEL);
   assign sel_id_o    = tgt_q;
   assign cmd_idx_o   = cmd_cnt_q;
   assign data_left_o = owed_q;
   assign status_o    = status_q;
   assign done_o      = done_q;

endmodule

// File: rtl/bus_phase_seq_chk.sv
module bus_phase_seq_chk
   import bus_phase_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] phase_o,
   input logic       sel_o,
   input logic       sel_ack_i,
   input logic       byte_req_o,
   input logic       byte_ack_i,
   input logic       bus_busy_i,
   input logic       done_o
);

   AST_ARB_ONLY_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o != PH_FREE) |=> (phase_o != PH_ARB)); // R2

   AST_NO_ARB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_FREE && bus_busy_i) |=> (phase_o != PH_ARB)); // R2

   AST_ARB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_ARB) |=> (phase_o == PH_SEL || phase_o == PH_FREE)); // R3

   AST_SEL_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o && !sel_ack_i) |=> sel_o); // R4

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_req_o && !byte_ack_i) |=> byte_req_o); // R5

   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_req_o && byte_ack_i) |=> !byte_req_o); // R5

   AST_STATUS_TO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_STATUS && byte_req_o && byte_ack_i) |=> (phase_o == PH_MSG)); // R8

   AST_DONE_IN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (phase_o == PH_FREE)); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_RESEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == PH_RESEL) |=> (phase_o == PH_DATA || phase_o == PH_STATUS)); // R10

endmodule

bind bus_phase_seq bus_phase_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase_o    (phase_o),
   .sel_o      (sel_o),
   .sel_ack_i  (sel_ack_i),
   .byte_req_o (byte_req_o),
   .byte_ack_i (byte_ack_i),
   .bus_busy_i (bus_busy_i),
   .done_o     (done_o)
);

// File: tb/bus_phase_seq_tb.sv
module bus_phase_seq_tb;

   localparam int ID_W = 8;
   localparam int OWN_ID = 3;
   localparam int CMD_LEN = 6;
   localparam int LEN_W = 8;
   localparam int IDX_W = 3;
   localparam int CW = 3;

   localparam int P_FREE = 0, P_ARB = 1, P_SEL = 2, P_RESEL = 3;
   localparam int P_CMD = 4, P_DATA = 5, P_MSG = 6, P_STATUS = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [IDX_W-1:0] tgt_id_i = '0;
   logic [LEN_W-1:0] data_len_i = '0;
   logic bus_busy_i = 1'b0;
   logic [ID_W-1:0] arb_req_i = '0;
   logic sel_ack_i = 1'b0;
   logic resel_i = 1'b0;
   logic [IDX_W-1:0] resel_id_i = '0;
   logic byte_ack_i = 1'b0;
   logic msg_req_i = 1'b0;
   logic [7:0] in_byte_i = '0;
   logic [2:0] phase_o;
   logic sel_o;
   logic [IDX_W-1:0] sel_id_o;
   logic byte_req_o;
   logic [CW-1:0] cmd_idx_o;
   logic [LEN_W-1:0] data_left_o;
   logic [7:0] status_o;
   logic done_o;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   bus_phase_seq #(.ID_W(ID_W), .OWN_ID(OWN_ID), .CMD_LEN(CMD_LEN), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_id_i(tgt_id_i),
      .data_len_i(data_len_i), .bus_busy_i(bus_busy_i), .arb_req_i(arb_req_i),
      .sel_ack_i(sel_ack_i), .resel_i(resel_i), .resel_id_i(resel_id_i),
      .byte_ack_i(byte_ack_i), .msg_req_i(msg_req_i), .in_byte_i(in_byte_i),
      .phase_o(phase_o), .sel_o(sel_o), .sel_id_o(sel_id_o), .byte_req_o(byte_req_o),
      .cmd_idx_o(cmd_idx_o), .data_left_o(data_left_o), .status_o(status_o),
      .done_o(done_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish, actual=%0d cycles expected=<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic bit own_wins(input logic [ID_W-1:0] mask);
      logic [ID_W-1:0] all;
      all = mask;
      all[OWN_ID] = 1'b1;
      for (int i = ID_W - 1; i >= 0; i--) begin
         if (all[i]) return (i == OWN_ID);
      end
      return 1'b0;
   endfunction

   function automatic int after_payload(input int owed);
      return (owed == 0) ? P_STATUS : P_DATA;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic byte_ack(input int ph, input logic [7:0] val, input logic mreq);
      chk("R5 request up", int'(byte_req_o), 1);
      chk("R5 phase at request", int'(phase_o), ph);
      in_byte_i = val;
      msg_req_i = mreq;
      byte_ack_i = 1'b1;
      step();
      chk("R5 request dropped after ack", int'(byte_req_o), 0);
      msg_req_i = 1'b0;
   endtask

   task automatic byte_rel();
      byte_ack_i = 1'b0;
      step();
   endtask

   task automatic begin_txn(input logic [IDX_W-1:0] tgt, input int len,
                            input logic [ID_W-1:0] mask, input int busy_cyc);
      tgt_id_i = tgt;
      data_len_i = LEN_W'(len);
      arb_req_i = mask;
      start_i = 1'b1;
      if (busy_cyc > 0) begin
         bus_busy_i = 1'b1;
         step();
         start_i = 1'b0;
         for (int b = 0; b < busy_cyc; b++) begin
            chk("R2 no arbitration while busy", int'(phase_o), P_FREE);
            step();
         end
         bus_busy_i = 1'b0;
      end
      step();
      start_i = 1'b0;
      chk("R2 arbitration from free", int'(phase_o), P_ARB);
      step();
      if (own_wins(mask)) begin
         chk("R3 win goes to selection", int'(phase_o), P_SEL);
      end else begin
         chk("R3 loss returns to free", int'(phase_o), P_FREE);
         arb_req_i = '0;
         step();
         chk("R3 retry arbitration", int'(phase_o), P_ARB);
         step();
         chk("R3 retry wins", int'(phase_o), P_SEL);
      end
      arb_req_i = '0;
      step();
      chk("R4 selection held", int'(sel_o), 1);
      chk("R4 target id", int'(sel_id_o), int'(tgt));
      sel_ack_i = 1'b1;
      step();
      sel_ack_i = 1'b0;
      chk("R4 command after ack", int'(phase_o), P_CMD);
      for (int c = 0; c < CMD_LEN; c++) begin
         chk("R6 command index", int'(cmd_idx_o), c);
         byte_ack(P_CMD, 8'(c + 8'h20), 1'b0);
         byte_rel();
      end
      chk("R6 phase after command", int'(phase_o), after_payload(len));
   endtask

   task automatic finish_txn(input logic [7:0] sbyte);
      byte_ack(P_STATUS, sbyte, 1'b0);
      chk("R8 message after status", int'(phase_o), P_MSG);
      chk("R8 status captured", int'(status_o), int'(sbyte));
      byte_rel();
      byte_ack(P_MSG, 8'h00, 1'b0);
      chk("R9 done pulse", int'(done_o), 1);
      chk("R9 free after complete", int'(phase_o), P_FREE);
      byte_rel();
      chk("R9 done one cycle", int'(done_o), 0);
   endtask

   task automatic run_txn(input logic [IDX_W-1:0] tgt, input int len,
                          input logic [ID_W-1:0] mask, input int disc_at,
                          input logic [7:0] sbyte);
      begin_txn(tgt, len, mask, 0);
      for (int j = 0; j < len; j++) begin
         chk("R7 bytes owed", int'(data_left_o), len - j);
         byte_ack(P_DATA, 8'(j), 1'(j == disc_at));
         byte_rel();
         if (j == disc_at) begin
            chk("R12 message on request", int'(phase_o), P_MSG);
            byte_ack(P_MSG, 8'h04, 1'b0);
            chk("R10 free after disconnect", int'(phase_o), P_FREE);
            byte_rel();
            start_i = 1'b1;
            step();
            start_i = 1'b0;
            chk("R10 start ignored while disconnected", int'(phase_o), P_FREE);
            resel_i = 1'b1;
            resel_id_i = tgt ^ 3'd1;
            step();
            chk("R10 wrong reselect id ignored", int'(phase_o), P_FREE);
            resel_id_i = tgt;
            step();
            resel_i = 1'b0;
            chk("R10 reselection", int'(phase_o), P_RESEL);
            step();
            chk("R10 resume after reselection", int'(phase_o), after_payload(len - j - 1));
            chk("R10 owed count kept", int'(data_left_o), len - j - 1);
         end
      end
      chk("R7 status after last byte", int'(phase_o), P_STATUS);
      finish_txn(sbyte);
   endtask

   initial begin
      logic [IDX_W-1:0] t;
      int len;
      logic [ID_W-1:0] m;
      void'($urandom(32'h5C5105));
      step();
      chk("R1 reset phase", int'(phase_o), P_FREE);
      chk("R1 reset select", int'(sel_o), 0);
      chk("R1 reset request", int'(byte_req_o), 0);
      chk("R1 reset done", int'(done_o), 0);
      rst_n = 1'b1;
      step();
      chk("R2 idle without start", int'(phase_o), P_FREE);

      // Directed: bus busy delays arbitration, zero-length transfer
      begin_txn(3'd5, 0, 8'h00, 3);
      finish_txn(8'h02);

      // Directed: higher competitor forces a loss and a retry
      run_txn(3'd1, 2, 8'h90, -1, 8'h00);

      // Directed: disconnect after the final data byte
      run_txn(3'd6, 2, 8'h05, 1, 8'h08);

      // Directed: save then restore pointer (R11)
      begin_txn(3'd2, 4, 8'h00, 0);
      byte_ack(P_DATA, 8'h11, 1'b1);
      byte_rel();
      chk("R12 message mid data", int'(phase_o), P_MSG);
      byte_ack(P_MSG, 8'h02, 1'b0);
      chk("R11 save resumes data", int'(phase_o), P_DATA);
      chk("R11 count after save", int'(data_left_o), 3);
      byte_rel();
      byte_ack(P_DATA, 8'h12, 1'b1);
      byte_rel();
      chk("R11 owed before restore", int'(data_left_o), 2);
      byte_ack(P_MSG, 8'h03, 1'b0);
      chk("R11 restore rewinds count", int'(data_left_o), 3);
      byte_rel();
      byte_ack(P_DATA, 8'h13, 1'b1);
      byte_rel();
      byte_ack(P_MSG, 8'h80, 1'b0);
      chk("R11 other message keeps count", int'(data_left_o), 2);
      chk("R11 other message resumes data", int'(phase_o), P_DATA);
      byte_rel();
      for (int k = 0; k < 2; k++) begin
         byte_ack(P_DATA, 8'h14, 1'b0);
         byte_rel();
      end
      finish_txn(8'h00);

      // Random transactions
      for (int n = 0; n < 24; n++) begin
         t = IDX_W'($urandom_range(0, ID_W - 1));
         if (t == IDX_W'(OWN_ID)) t = IDX_W'(0);
         len = $urandom_range(0, 5);
         m = ID_W'($urandom_range(0, 255));
         if ($urandom_range(0, 1) == 0) m = m & ID_W'((1 << OWN_ID) - 1);
         run_txn(t, len, m, (len > 0 && $urandom_range(0, 2) == 0) ? $urandom_range(0, len - 1) : -1,
                 8'($urandom_range(0, 255)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule